// File: doc/BRIEF.md
# Three-source reset sequencer

This block sequences the resets of a processor-style chip from three active-low inputs: power-on, hard and soft. Any of them may change at any moment, with no relation to the reference clock. Each input is first brought into the reference clock domain. A low level then counts as a reset request only once it has been seen for a minimum number of consecutive reference cycles, so short glitches are discarded.

A power-on request resets everything. It pulls the hard and soft reset pin drives low, and they stay low through a fixed stretch after the request ends. A hard request resets the core and peripheral levels, and each time one is released a stretch of the same length follows. A soft request resets only the peripheral level, which comes back as soon as the request goes away.

Power-on outranks hard, and hard outranks soft. A 2-bit cause field reports which source started the most recent reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: Each input passes through two reference-clock flops before it is examined. A low level that lasts fewer than MIN_W (default 4) consecutive reference cycles changes no output. This applies to every input, including a power-on pulse that arrives after start-up.
- R2: A low level that lasts MIN_W or more cycles is accepted. The outputs it drives go low at the (MIN_W+2)-th rising edge, counting from the first edge at which the input is low.
- R3: While an accepted power-on request is active, all four reset outputs are low and the cause field reads 0.
- R4: After power-on is released, all four outputs stay low for STRETCH (default 4096) further cycles. They then rise together at the (STRETCH+3)-th rising edge, counting from the first edge at which the input is high.
- R5: An accepted hard request holds core_rst_n and soft_rst_n low and leaves both pin drives high. After release, both outputs rise at the (STRETCH+3)-th edge, counting from the first edge with the input high.
- R6: An accepted soft request holds only soft_rst_n low. It has no stretch: soft_rst_n rises at the third edge, counting from the first edge with the input high. core_rst_n and the pin drives stay high.
- R7: An accepted higher-ranking request restarts the sequence at its own level, whether the lower-ranking one is held or stretching. A lower-ranking request that arrives during a higher-ranking hold or stretch has no effect.
- R8: A soft request during a hard stretch neither restarts nor lengthens that stretch.
- R9: rst_cause reads 0 after power-on, 1 after hard and 2 after soft. It is loaded when a request is accepted and holds its value otherwise. Only a power-on request returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n_in | input | 1 | Power-on reset request, active low, asynchronous |
| hard_n_in | input | 1 | Hard reset request, active low, asynchronous |
| soft_n_in | input | 1 | Soft reset request, active low, asynchronous |
| core_rst_n | output | 1 | Internal core reset, active low |
| soft_rst_n | output | 1 | Internal peripheral reset, active low |
| hard_drv_n | output | 1 | Hard reset pin drive, active low |
| soft_drv_n | output | 1 | Soft reset pin drive, active low |
| rst_cause | output | 2 | Source of the most recent reset |

## Verification
The hardest situations to reach are those where one request lands inside another's hold or stretch, together with pulses of exactly MIN_W-1 and MIN_W cycles. Some of these pulses must be ignored and some must restart the sequence.

Inputs are driven on falling clock edges, which fixes the number of samples each pulse gets. The bench places a hard pulse inside the power-on stretch and a soft pulse inside the hard stretch. It places a hard request on top of a held soft request, and both a short and a full-width power-on pulse inside a hard stretch. For each case it checks the exact edge at which the outputs rise.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int MIN_W   = 4,
  parameter int STRETCH = 4096
) (
  input  logic       clk,
  input  logic       por_n_in,
  input  logic       hard_n_in,
  input  logic       soft_n_in,
  output logic       core_rst_n,
  output logic       soft_rst_n,
  output logic       hard_drv_n,
  output logic       soft_drv_n,
  output logic [1:0] rst_cause
);
  localparam int LW = (MIN_W > 2) ? $clog2(MIN_W) : 1;
  localparam int SW = $clog2(STRETCH);
  localparam logic [LW-1:0] LMAX = LW'(MIN_W - 1);
  localparam logic [SW-1:0] SMAX = SW'(STRETCH - 1);

  typedef enum logic [2:0] {
    ST_PHOLD = 3'd0,
    ST_PSTR  = 3'd1,
    ST_HHOLD = 3'd2,
    ST_HSTR  = 3'd3,
    ST_SHOLD = 3'd4,
    ST_RUN   = 3'd5
  } st_t;

  logic [2:0]    raw, m1, m2, act;
  st_t           st, nxt;
  logic [SW-1:0] sc;

  assign raw = {soft_n_in, hard_n_in, por_n_in};

  always_ff @(posedge clk) begin
    m1 <= raw;
    m2 <= m1;
  end

  for (genvar i = 0; i < 3; i++) begin : g_qual
    logic [LW-1:0] lo;
    always_ff @(posedge clk) begin
      if (m2[i])          lo <= '0;
      else if (lo != LMAX) lo <= lo + 1'b1;
    end
    assign act[i] = !m2[i] && (lo == LMAX);
  end

  always_comb begin
    nxt = st;
    case (st)
      ST_PHOLD: nxt = ST_PSTR;
      ST_PSTR:  if (sc == SMAX) nxt = ST_RUN;
      ST_HHOLD: if (!act[1]) nxt = ST_HSTR;
      ST_HSTR:  if (act[1]) nxt = ST_HHOLD;
                else if (sc == SMAX) nxt = ST_RUN;
      ST_SHOLD: if (act[1]) nxt = ST_HHOLD;
                else if (!act[2]) nxt = ST_RUN;
      ST_RUN:   if (act[1]) nxt = ST_HHOLD;
                else if (act[2]) nxt = ST_SHOLD;
      default:  nxt = ST_PHOLD;
    endcase
    if (act[0]) nxt = ST_PHOLD;
  end

  always_ff @(posedge clk) begin
    st <= nxt;
    if ((st == ST_PSTR || st == ST_HSTR) && nxt == st) sc <= sc + 1'b1;
    else                                               sc <= '0;
    core_rst_n <= !(nxt inside {ST_PHOLD, ST_PSTR, ST_HHOLD, ST_HSTR});
    soft_rst_n <= (nxt == ST_RUN);
    hard_drv_n <= !(nxt inside {ST_PHOLD, ST_PSTR});
    soft_drv_n <= !(nxt inside {ST_PHOLD, ST_PSTR});
    if (nxt == ST_PHOLD)      rst_cause <= 2'd0;
    else if (nxt == ST_HHOLD) rst_cause <= 2'd1;
    else if (nxt == ST_SHOLD) rst_cause <= 2'd2;
  end

  // R1
  hold_needs_low_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    (st == ST_HHOLD) |-> !$past(m2[1]));
  // R4
  stretch_len_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    $rose(core_rst_n) |-> ($past(sc) == SMAX));
  // R5
  pins_por_only_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    !hard_drv_n |-> (rst_cause == 2'd0 && !core_rst_n));
  // R6
  soft_only_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    (st == ST_SHOLD) |-> (core_rst_n && hard_drv_n && soft_drv_n));
  // R7
  level_order_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    !core_rst_n |-> !soft_rst_n);
  // R8
  stretch_steady_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    (st == ST_HSTR && $past(st) == ST_HSTR) |-> (sc == $past(sc) + 1'b1));
  // R9
  cause_clear_chk: assert property (@(posedge clk) disable iff (!por_n_in)
    (rst_cause == 2'd0 && $past(rst_cause) != 2'd0) |-> (st == ST_PHOLD));
endmodule

// File: tb/rst_seq_ctrl_bench.sv
module rst_seq_ctrl_bench;
  localparam int CLK_NS  = 10;
  localparam int MIN_W   = 4;
  localparam int STRETCH = 4096;
  localparam int MP = 0, MPS = 1, MH = 2, MHS = 3, MS = 4, MR = 5;

  logic clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic por_n = 1'b0, hard_n = 1'b1, soft_n = 1'b1;
  logic core_rst_n, soft_rst_n, hard_drv_n, soft_drv_n;
  logic [1:0] rst_cause;

  rst_seq_ctrl #(.MIN_W(MIN_W), .STRETCH(STRETCH)) u_rst_seq_ctrl (
    .clk(clk), .por_n_in(por_n), .hard_n_in(hard_n), .soft_n_in(soft_n),
    .core_rst_n(core_rst_n), .soft_rst_n(soft_rst_n),
    .hard_drv_n(hard_drv_n), .soft_drv_n(soft_drv_n), .rst_cause(rst_cause));

  int errors = 0, checks = 0;
  bit cmp_on = 0, done = 0;

  int m_s1[3] = '{0, 1, 1};
  int m_s2[3] = '{0, 1, 1};
  int m_lo[3] = '{0, 0, 0};
  int m_st = MP, m_sc = 0, m_cause = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic nwait(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin : model
    int nst;
    bit ap, ah, as;
    ap = (m_s2[0] == 0) && (m_lo[0] >= MIN_W - 1);
    ah = (m_s2[1] == 0) && (m_lo[1] >= MIN_W - 1);
    as = (m_s2[2] == 0) && (m_lo[2] >= MIN_W - 1);
    if (ap) nst = MP;
    else if (m_st == MP) nst = MPS;
    else if (m_st == MPS) nst = (m_sc == STRETCH - 1) ? MR : MPS;
    else if (ah) nst = MH;
    else if (m_st == MH) nst = MHS;
    else if (m_st == MHS) nst = (m_sc == STRETCH - 1) ? MR : MHS;
    else if (m_st == MS) nst = as ? MS : MR;
    else if (as) nst = MS;
    else nst = MR;
    if ((m_st == MPS || m_st == MHS) && nst == m_st) m_sc++;
    else m_sc = 0;
    if (nst == MP) m_cause = 0;
    else if (nst == MH) m_cause = 1;
    else if (nst == MS) m_cause = 2;
    m_st = nst;
    for (int i = 0; i < 3; i++)
      m_lo[i] = (m_s2[i] != 0) ? 0 : ((m_lo[i] < MIN_W - 1) ? m_lo[i] + 1 : m_lo[i]);
    for (int i = 0; i < 3; i++) m_s2[i] = m_s1[i];
    m_s1[0] = int'(por_n);
    m_s1[1] = int'(hard_n);
    m_s1[2] = int'(soft_n);
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R5", "core_rst_n", int'(core_rst_n),
          (m_st == MP || m_st == MPS || m_st == MH || m_st == MHS) ? 0 : 1);
      chk("R6", "soft_rst_n", int'(soft_rst_n), (m_st == MR) ? 1 : 0);
      chk("R4", "hard_drv_n", int'(hard_drv_n), (m_st == MP || m_st == MPS) ? 0 : 1);
      chk("R4", "soft_drv_n", int'(soft_drv_n), (m_st == MP || m_st == MPS) ? 0 : 1);
      chk("R9", "rst_cause", int'(rst_cause), m_cause);
    end
  end

  initial begin
    #(CLK_NS * 60000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    nwait(20);
    cmp_on = 1;
    // R3 reset state under a held power-on request
    chk("R3", "core_rst_n", int'(core_rst_n), 0);
    chk("R3", "soft_rst_n", int'(soft_rst_n), 0);
    chk("R3", "hard_drv_n", int'(hard_drv_n), 0);
    chk("R3", "rst_cause", int'(rst_cause), 0);

    // R4 power-on release, with a hard pulse inside the stretch (R7)
    por_n = 1'b1;
    nwait(100); hard_n = 1'b0; nwait(5); hard_n = 1'b1;
    nwait(STRETCH + 2 - 105);
    chk("R4", "core_rst_n before stretch end", int'(core_rst_n), 0);
    chk("R7", "soft_drv_n before stretch end", int'(soft_drv_n), 0);
    nwait(1);
    chk("R4", "core_rst_n after stretch", int'(core_rst_n), 1);
    chk("R4", "hard_drv_n after stretch", int'(hard_drv_n), 1);
    chk("R7", "rst_cause after hard in stretch", int'(rst_cause), 0);

    // R1 three-cycle hard pulse ignored
    nwait(10); hard_n = 1'b0; nwait(MIN_W - 1); hard_n = 1'b1; nwait(12);
    chk("R1", "core_rst_n after short hard", int'(core_rst_n), 1);

    // R2 four-cycle hard pulse, R8 soft pulse inside the hard stretch
    hard_n = 1'b0; nwait(MIN_W); hard_n = 1'b1;
    nwait(1);
    chk("R2", "core_rst_n one edge early", int'(core_rst_n), 1);
    nwait(1);
    chk("R2", "core_rst_n on accept", int'(core_rst_n), 0);
    chk("R5", "hard_drv_n during hard", int'(hard_drv_n), 1);
    chk("R9", "rst_cause hard", int'(rst_cause), 1);
    nwait(994); soft_n = 1'b0; nwait(6); soft_n = 1'b1;
    nwait(STRETCH + 6 - 1006);
    chk("R8", "core_rst_n before hard stretch end", int'(core_rst_n), 0);
    nwait(1);
    chk("R8", "core_rst_n after hard stretch", int'(core_rst_n), 1);
    chk("R5", "soft_rst_n after hard stretch", int'(soft_rst_n), 1);
    chk("R9", "rst_cause kept after soft in stretch", int'(rst_cause), 1);

    // R1 short soft pulse, R6 accepted soft pulse
    nwait(10); soft_n = 1'b0; nwait(MIN_W - 1); soft_n = 1'b1; nwait(10);
    chk("R1", "soft_rst_n after short soft", int'(soft_rst_n), 1);
    chk("R9", "rst_cause after short soft", int'(rst_cause), 1);
    soft_n = 1'b0; nwait(5); soft_n = 1'b1; nwait(2);
    chk("R6", "soft_rst_n held", int'(soft_rst_n), 0);
    chk("R6", "core_rst_n during soft", int'(core_rst_n), 1);
    chk("R6", "hard_drv_n during soft", int'(hard_drv_n), 1);
    chk("R9", "rst_cause soft", int'(rst_cause), 2);
    nwait(1);
    chk("R6", "soft_rst_n released", int'(soft_rst_n), 1);

    // R7 hard over a held soft request
    nwait(10); soft_n = 1'b0; nwait(10); hard_n = 1'b0; nwait(6); hard_n = 1'b1; nwait(2);
    chk("R7", "core_rst_n hard over soft", int'(core_rst_n), 0);
    chk("R7", "rst_cause hard over soft", int'(rst_cause), 1);
    soft_n = 1'b1; nwait(STRETCH + 100);
    chk("R7", "core_rst_n after", int'(core_rst_n), 1);
    chk("R7", "soft_rst_n after", int'(soft_rst_n), 1);

    // R1 short power-on pulse in hard stretch, R7 full pulse restarts at power-on
    hard_n = 1'b0; nwait(6); hard_n = 1'b1; nwait(300);
    por_n = 1'b0; nwait(MIN_W - 1); por_n = 1'b1; nwait(5);
    chk("R1", "hard_drv_n after short power-on", int'(hard_drv_n), 1);
    chk("R1", "rst_cause after short power-on", int'(rst_cause), 1);
    por_n = 1'b0; nwait(MIN_W); por_n = 1'b1; nwait(3);
    chk("R7", "hard_drv_n power-on over hard", int'(hard_drv_n), 0);
    chk("R3", "rst_cause power-on", int'(rst_cause), 0);
    nwait(STRETCH + 100);
    chk("R4", "all released core", int'(core_rst_n), 1);
    chk("R4", "all released pins", int'(soft_drv_n), 1);

    por_n = 1'b0; nwait(MIN_W - 1); por_n = 1'b1; nwait(10);
    chk("R1", "core_rst_n after power-on glitch", int'(core_rst_n), 1);
    chk("R1", "hard_drv_n after power-on glitch", int'(hard_drv_n), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule